// File: doc/BRIEF.md
# Cycle-Pair Clock Correction Scheduler

This block sits between a host register interface and the protocol engine of a time-triggered bus controller. The host posts external clock corrections of two kinds: an offset correction and a rate correction. The block holds each posted value and releases it to the correction datapath at the right point of the even/odd communication cycle schedule. Offset values are released in the network idle time (NIT) of an odd cycle. Rate values are released at the start of an even cycle, which begins the cycle pair they govern. A request that arrives too late for the nearest slot is deferred by one whole cycle pair.

The protocol engine supplies single-clock strobes for cycle start, static segment end and NIT start, and a parity flag for the current cycle. The block produces, for each path, a one-clock apply strobe and the value being applied. The two paths are independent. Leaving normal operation drops everything that is pending.

Top module: `corr_pair_scheduler`

## Requirements
- R1: An offset apply strobe is raised only in the clock after a `nit_start` strobe seen while `cyc_odd` is 1 and `eng_normal` is 1.
- R2: An offset write made from the start of even cycle 2n up to the clock before the static segment end strobe of odd cycle 2n+1 is applied one clock after the NIT start of cycle 2n+1.
- R3: An offset write made in an odd cycle in the clock of its static segment end strobe, or later in that cycle, is applied one clock after the NIT start of the odd cycle two cycles later.
- R4: A rate apply strobe is raised only in the clock after a `cyc_start` strobe seen while `cyc_odd` is 0 and `eng_normal` is 1. A rate write made from the start of even cycle 2n up to the clock before the static segment end of cycle 2n+1 is applied at the start of cycle 2n+2.
- R5: A rate write made in odd cycle 2n+1 in the clock of its static segment end strobe, or later in that cycle, is applied at the start of cycle 2n+4.
- R6: The offset and rate paths are independent: a write to one path never produces a strobe on the other, and each path keeps its own target cycle.
- R7: A second write to a path with a request still pending replaces the pending value. An already earned target is kept even if the second write is late. A late request that is rewritten in the window takes the target of the window.
- R8: Each request produces exactly one apply strobe, one clock wide, with the value on `ofs_value`/`rate_value` in that clock. The value output changes only with its strobe and holds afterwards.
- R9: Reset, or `eng_normal` at 0 for any clock, discards all pending requests. No strobe is raised in the clock after `eng_normal` is 0. Reset also sets the strobes and values to 0.
- R10: A write in the same clock as a `cyc_start` strobe counts as made in the cycle that starts, at the start of its window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| eng_normal | input | 1 | Protocol engine is in normal operation; 0 discards pending requests |
| cyc_start | input | 1 | One-clock strobe at the start of a communication cycle |
| cyc_odd | input | 1 | Parity of the current cycle (1 = odd); valid in the `cyc_start` clock for the cycle that starts |
| sseg_end | input | 1 | One-clock strobe at the end of the static segment |
| nit_start | input | 1 | One-clock strobe at the start of the network idle time |
| ofs_wr | input | 1 | Host write of an external offset correction |
| ofs_wdata | input | OFS_W | Offset correction value written |
| rate_wr | input | 1 | Host write of an external rate correction |
| rate_wdata | input | RATE_W | Rate correction value written |
| ofs_apply | output | 1 | One-clock strobe: offset correction applied now |
| ofs_value | output | OFS_W | Offset value applied, held between strobes |
| rate_apply | output | 1 | One-clock strobe: rate correction applied now |
| rate_value | output | RATE_W | Rate value applied, held between strobes |

## Verification
A wrong pending or eligibility bit makes a strobe appear a whole cycle pair early or late, or not at all. The bench sees this within about four communication cycles of the write, so every trial runs six cycles. A wrong late/early decision shows up at exactly the two boundary write positions: the clock before and the clock of the odd static-segment-end strobe. The sweep writes at every clock of a cycle pair, so both positions are covered on both paths. A stale value register shows up as a wrong value next to a correctly timed strobe. Failing to discard a request shows up as a stray strobe after a drop of normal operation or after a reset.

// File: rtl/corr_pkg.sv
package corr_pkg;
  localparam int unsigned OFS_W_DEF    = 16;
  localparam int unsigned RATE_W_DEF   = 12;
  localparam int unsigned SYNC_DEPTH   = 2;

  typedef struct packed {
    logic pend;
    logic elig;
  } slot_flags_t;
endpackage

// File: rtl/corr_rst_sync.sv
module corr_rst_sync #(
  parameter int unsigned STAGES = corr_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int unsigned MSB = STAGES - 1;

  logic [MSB:0] chain_q;
  logic [MSB:0] chain_n;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_n = 1'b1;
    end else begin : g_many
      always_comb chain_n = {chain_q[MSB-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign rst_sync_n = chain_q[MSB];
endmodule

// File: rtl/corr_phase_track.sv
module corr_phase_track (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cyc_start,
  input  logic cyc_odd,
  input  logic sseg_end,
  output logic late_now
);
  logic late_q;
  logic late_n;
  logic odd_sseg;

  assign odd_sseg = sseg_end & cyc_odd;

  always_comb begin
    late_n = late_q;
    if (!run)           late_n = 1'b0;
    else if (cyc_start) late_n = 1'b0;
    else if (odd_sseg)  late_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) late_q <= 1'b0;
    else        late_q <= late_n;
  end

  // A write in a cycle-start clock belongs to the new cycle (R10);
  // the odd static-end clock itself is already late (R3, R5).
  assign late_now = (late_q | odd_sseg) & ~cyc_start;

  assert_late_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && odd_sseg && !cyc_start) |=> late_q);
  assert_late_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start || !run) |=> !late_q);
endmodule

// File: rtl/corr_req_slot.sv
module corr_req_slot #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         late_now,
  input  logic         promote,
  input  logic         apply_evt,
  output logic         apply_stb,
  output logic [W-1:0] apply_val
);
  import corr_pkg::*;

  slot_flags_t  flg_q, flg_n;
  logic [W-1:0] hold_q;
  logic [W-1:0] out_q;
  logic         stb_q, stb_n;
  logic         fire;
  logic         hold_en;
  logic         out_en;

  assign fire    = apply_evt & flg_q.pend & flg_q.elig & ~flush;
  assign hold_en = wr & ~flush;
  assign out_en  = fire;

  always_comb begin
    flg_n = flg_q;
    stb_n = fire;
    if (flush) begin
      flg_n = '0;
      stb_n = 1'b0;
    end else if (wr) begin
      flg_n.pend = 1'b1;
      // keep an earned target unless it is being consumed now (R7)
      flg_n.elig = ~late_now | (flg_q.pend & flg_q.elig & ~fire);
    end else if (fire) begin
      flg_n = '0;
    end else if (promote && flg_q.pend) begin
      flg_n.elig = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      stb_q <= 1'b0;
    end else begin
      flg_q <= flg_n;
      stb_q <= stb_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= hold_q;
  end

  assign apply_stb = stb_q;
  assign apply_val = out_q;

  assert_late_deferred_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && late_now && !flush && !(flg_q.pend && flg_q.elig)) |=> (flg_q.pend && !flg_q.elig));
  assert_keep_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !flush && flg_q.pend && flg_q.elig && !apply_evt) |=> (flg_q.pend && flg_q.elig));
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!flg_q.pend && !stb_q));
  assert_strobe_consumes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q && !$past(wr)) |-> !flg_q.pend);
endmodule

// File: rtl/corr_pair_scheduler.sv
module corr_pair_scheduler #(
  parameter int unsigned OFS_W      = corr_pkg::OFS_W_DEF,
  parameter int unsigned RATE_W     = corr_pkg::RATE_W_DEF,
  parameter int unsigned RST_STAGES = corr_pkg::SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_normal,
  input  logic              cyc_start,
  input  logic              cyc_odd,
  input  logic              sseg_end,
  input  logic              nit_start,
  input  logic              ofs_wr,
  input  logic [OFS_W-1:0]  ofs_wdata,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_wdata,
  output logic              ofs_apply,
  output logic [OFS_W-1:0]  ofs_value,
  output logic              rate_apply,
  output logic [RATE_W-1:0] rate_value
);
  logic rst_i_n;
  logic late_now;
  logic flush;
  logic ofs_evt;
  logic rate_evt;

  corr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  corr_phase_track u_phase (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .run       (eng_normal),
    .cyc_start (cyc_start),
    .cyc_odd   (cyc_odd),
    .sseg_end  (sseg_end),
    .late_now  (late_now)
  );

  assign flush    = ~eng_normal;
  assign ofs_evt  = nit_start & cyc_odd;
  assign rate_evt = cyc_start & ~cyc_odd;

  corr_req_slot #(.W(OFS_W)) u_ofs (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .flush     (flush),
    .wr        (ofs_wr),
    .wdata     (ofs_wdata),
    .late_now  (late_now),
    .promote   (cyc_start),
    .apply_evt (ofs_evt),
    .apply_stb (ofs_apply),
    .apply_val (ofs_value)
  );

  corr_req_slot #(.W(RATE_W)) u_rate (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .flush     (flush),
    .wr        (rate_wr),
    .wdata     (rate_wdata),
    .late_now  (late_now),
    .promote   (cyc_start),
    .apply_evt (rate_evt),
    .apply_stb (rate_apply),
    .apply_val (rate_value)
  );

  assert_ofs_in_odd_nit_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    ofs_apply |-> $past(nit_start && cyc_odd && eng_normal));
  assert_rate_at_even_start_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    rate_apply |-> $past(cyc_start && !cyc_odd && eng_normal));
  assert_ofs_value_hold_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    !ofs_apply |-> $stable(ofs_value));
  assert_rate_value_hold_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rate_apply |-> $stable(rate_value));
  assert_quiet_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    $past(!eng_normal) |-> (!ofs_apply && !rate_apply));
endmodule

// File: tb/sim_corr_pair_scheduler.sv
module sim_corr_pair_scheduler;
  localparam int CLK_PERIOD = 10;
  localparam int OW = 16;
  localparam int RW = 12;
  localparam int CL = 12;  // clocks per communication cycle
  localparam int SS = 5;   // static segment end phase
  localparam int NI = 9;   // NIT start phase
  localparam int TRIAL = 6 * CL;

  logic clk = 1'b0;
  logic rst_n;
  logic eng_normal;
  logic cyc_start, cyc_odd, sseg_end, nit_start;
  logic ofs_wr, rate_wr;
  logic [OW-1:0] ofs_wdata;
  logic [RW-1:0] rate_wdata;
  logic ofs_apply, rate_apply;
  logic [OW-1:0] ofs_value;
  logic [RW-1:0] rate_value;

  int t = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  corr_pair_scheduler #(.OFS_W(OW), .RATE_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .eng_normal(eng_normal),
    .cyc_start(cyc_start), .cyc_odd(cyc_odd), .sseg_end(sseg_end), .nit_start(nit_start),
    .ofs_wr(ofs_wr), .ofs_wdata(ofs_wdata), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
    .ofs_apply(ofs_apply), .ofs_value(ofs_value),
    .rate_apply(rate_apply), .rate_value(rate_value)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", tag, act, exp, t);
    end
  endtask

  // Drive step t's inputs, pass one rising edge, sample at the falling edge.
  task automatic step(input bit ow, input logic [OW-1:0] ov,
                      input bit rw, input logic [RW-1:0] rv,
                      input bit run, input bit rst);
    int p, c;
    p = t % CL;
    c = t / CL;
    cyc_start  = (p == 0);
    sseg_end   = (p == SS);
    nit_start  = (p == NI);
    cyc_odd    = ((c % 2) == 1);
    eng_normal = run;
    rst_n      = !rst;
    ofs_wr     = ow;
    ofs_wdata  = ov;
    rate_wr    = rw;
    rate_wdata = rv;
    @(posedge clk);
    @(negedge clk);
    t++;
  endtask

  function automatic int ofs_due(input int tw);
    int c, p, g;
    c = tw / CL;
    p = tw % CL;
    if ((c % 2) == 1) g = (p < SS) ? c : c + 2;
    else              g = c + 1;
    return g * CL + NI;
  endfunction

  function automatic int rate_due(input int tw);
    int c, p, g;
    c = tw / CL;
    p = tw % CL;
    if ((c % 2) == 0) g = c + 2;
    else              g = (p < SS) ? c + 1 : c + 3;
    return g * CL;
  endfunction

  task automatic align();
    while ((t % (2 * CL)) != 0) step(0, '0, 0, '0, 1, 0);
  endtask

  // One trial: writes at offsets wa (value A) and wb (value B, -1 = none).
  // Expected due steps are absolute; -1 means no strobe expected.
  task automatic trial(input int wa, input int wb, input bit do_o, input bit do_r,
                       input int kill_at, input int rst_at,
                       input int exp_o, input int exp_r,
                       input logic [OW-1:0] vo, input logic [RW-1:0] vr,
                       input string tag_o, input string tag_r);
    int base, n_o, n_r, at_o, at_r;
    logic [OW-1:0] got_o;
    logic [RW-1:0] got_r;
    base = t;
    n_o = 0; n_r = 0; at_o = -1; at_r = -1; got_o = '0; got_r = '0;
    for (int i = 0; i < TRIAL; i++) begin
      bit hit, run, rs;
      int now;
      logic [OW-1:0] ov;
      logic [RW-1:0] rv;
      hit = (i == wa) || (i == wb);
      ov  = (i == wa) ? OW'(16'h1000 + wa) : OW'(16'h2000 + wb);
      rv  = (i == wa) ? RW'(12'h300 + wa)  : RW'(12'h500 + wb);
      run = !(kill_at >= 0 && i >= kill_at && i < kill_at + 3);
      rs  = (rst_at >= 0 && i == rst_at);
      now = t;
      step(do_o && hit, ov, do_r && hit, rv, run, rs);
      if (ofs_apply)  begin n_o++; at_o = now; got_o = ofs_value; end
      if (rate_apply) begin n_r++; at_r = now; got_r = rate_value; end
    end
    if (exp_o >= 0) begin
      chk(n_o == 1, {tag_o, " offset strobe count"}, n_o, 1);
      chk(at_o == base + exp_o, {tag_o, " offset strobe step"}, at_o - base, exp_o);
      chk(got_o == vo, {tag_o, " offset value"}, int'(got_o), int'(vo));
      chk(ofs_value == vo, {tag_o, " R8 offset value held"}, int'(ofs_value), int'(vo));
    end else begin
      chk(n_o == 0, {tag_o, " no offset strobe"}, n_o, 0);
    end
    if (exp_r >= 0) begin
      chk(n_r == 1, {tag_r, " rate strobe count"}, n_r, 1);
      chk(at_r == base + exp_r, {tag_r, " rate strobe step"}, at_r - base, exp_r);
      chk(got_r == vr, {tag_r, " rate value"}, int'(got_r), int'(vr));
      chk(rate_value == vr, {tag_r, " R8 rate value held"}, int'(rate_value), int'(vr));
    end else begin
      chk(n_r == 0, {tag_r, " no rate strobe"}, n_r, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; eng_normal = 1'b0;
    cyc_start = 0; cyc_odd = 0; sseg_end = 0; nit_start = 0;
    ofs_wr = 0; rate_wr = 0; ofs_wdata = '0; rate_wdata = '0;
    repeat (3) @(negedge clk);
    chk(!ofs_apply && !rate_apply, "R9 reset strobes low", int'(ofs_apply) + int'(rate_apply), 0);
    chk(ofs_value == '0 && rate_value == '0, "R9 reset values zero",
        int'(ofs_value) + int'(rate_value), 0);
    t = 0;
    repeat (2 * CL) step(0, '0, 0, '0, 1, 0);

    // Sweep every write position in a cycle pair on both paths at once (R6).
    for (int w = 0; w < 2 * CL; w++) begin
      string to, tr;
      int b;
      align();
      b = t;
      if (w >= CL + SS) to = "R3"; else if (w == CL) to = "R10"; else to = "R2";
      if (w >= CL + SS) tr = "R5"; else if (w == CL) tr = "R10"; else tr = "R4";
      trial(w, -1, 1, 1, -1, -1,
            ofs_due(b + w) - b, rate_due(b + w) - b,
            OW'(16'h1000 + w), RW'(12'h300 + w), to, tr);
    end

    // R6: one path alone, including the late boundary clock.
    align();
    trial(CL + SS, -1, 1, 0, -1, -1, 3 * CL + NI, -1,
          OW'(16'h1000 + CL + SS), '0, "R6 R3", "R6");
    align();
    trial(CL + SS - 1, -1, 0, 1, -1, -1, -1, 2 * CL,
          '0, RW'(12'h300 + CL + SS - 1), "R6", "R6 R4");

    // R7: window write then late rewrite keeps the early target with the new value.
    align();
    trial(2, CL + SS + 1, 1, 1, -1, -1, CL + NI, 2 * CL,
          OW'(16'h2000 + CL + SS + 1), RW'(12'h500 + CL + SS + 1), "R7", "R7");
    // R7: late write then window rewrite takes the window target.
    align();
    trial(CL + SS + 1, 2 * CL + 1, 1, 1, -1, -1, 3 * CL + NI, 4 * CL,
          OW'(16'h2000 + 2 * CL + 1), RW'(12'h500 + 2 * CL + 1), "R7", "R7");

    // R9: dropping normal operation discards pending requests.
    align();
    trial(2, -1, 1, 1, 4, -1, -1, -1, '0, '0, "R9 stop", "R9 stop");
    // R9: reset discards pending requests and clears values.
    align();
    trial(2, -1, 1, 1, -1, CL + 2, -1, -1, '0, '0, "R9 reset", "R9 reset");
    chk(ofs_value == '0 && rate_value == '0, "R9 values cleared by reset",
        int'(ofs_value) + int'(rate_value), 0);

    // R1/R8: after the discards, a fresh request is applied once as usual.
    align();
    trial(3, -1, 1, 1, -1, -1, CL + NI, 2 * CL,
          OW'(16'h1003), RW'(12'h303), "R1 R8", "R4 R8");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", t, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule